// File: doc/BRIEF.md
# Strobe-Latched Control Register Bank

This block receives control words from a shared 8-bit parallel bus and keeps them in three independent registers: a system control word (input relay, phantom supply, hardware mute, input source selection, codec power), a monitor routing word, and a clock configuration word. No address bus exists. Each register has its own active-low select line. A shared active-low output-enable line qualifies every write. The master puts a byte on the bus, pulls output enable low, and pulses one select low and then high. The addressed register loads the byte when that select rises, provided output enable is still low at that moment.

The bus lines and strobes are asynchronous to the block's clock. All of them pass through a synchronizer chain of `SYNC_STAGES` flops. Each register has a two-state capture machine that tracks its synchronized select:
- `ST_SEL_HIGH` moves to `ST_SEL_LOW` when the select is seen low.
- `ST_SEL_LOW` moves back to `ST_SEL_HIGH` when the select is seen high. That return transition is the rising edge, and it issues a one-cycle load pulse only if the synchronized output enable is low.

The system control and monitor words are also decoded into named control outputs. A sticky flag reports any write of the unsupported input-source code.

Top module: `ext_reg_bank`

## Requirements
- R1: Reset values:
  - system word 0x08 (phantom disabled, codec held in power-down);
  - monitor word 0x00 and clock word 0x00;
  - error flag 0.
- R2: When a select rises while output enable is low, the addressed register takes the bus byte. The new value appears after the third rising clock edge that follows the select rise, with the default synchronizer depth of 2.
- R3: A select rise while output enable is high leaves the register unchanged.
- R4: A write through one select leaves the other two registers unchanged.
- R5: A select that stays low does not load anything, even if the bus changes while it is low. Only the value on the bus at the rise is taken.
- R6: System word decode:
  - bit 0 is mic relay;
  - bit 1 is high phantom voltage;
  - bit 2 is hardware mute;
  - bit 3 is phantom off;
  - bits 5:4 are the input 1/2 source (00 line, 01 mic, 11 mic with low-cut);
  - bit 6 is hi-Z on input 3/4;
  - bit 7 is codec running (power-down released).
- R7: Monitor word decode:
  - bits 3:0 drive the four input-to-monitor paths;
  - bit 4 routes output 3/4 to monitor 1/2;
  - bit 5 routes output 1/2 to monitor 3/4.
- R8: A system write with bits 5:4 = 10 is stored exactly as written and sets the error flag. The flag stays set through later writes until reset.
- R9: System writes with a legal source code leave the error flag at 0.
- R10: Selects that rise together in the same cycle all load the same bus byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_data | input | 8 | Shared parallel data bus |
| bus_oe_n | input | 1 | Active-low write qualifier |
| sel_sys_n | input | 1 | Active-low select, system word |
| sel_mon_n | input | 1 | Active-low select, monitor word |
| sel_clk_n | input | 1 | Active-low select, clock word |
| sys_word | output | 8 | Stored system word |
| mon_word | output | 8 | Stored monitor word |
| clk_word | output | 8 | Stored clock configuration word |
| mic_relay | output | 1 | Input 1/2 relay set to mic |
| phantom_hi_v | output | 1 | High phantom voltage selected |
| hw_mute | output | 1 | Hardware mute |
| phantom_off | output | 1 | Phantom power disabled |
| in12_src | output | 2 | Input 1/2 source code |
| in34_hiz | output | 1 | Input 3/4 hi-Z selected |
| codec_run | output | 1 | Codec out of power-down |
| mon_in_paths | output | 4 | Input-to-monitor path enables |
| out34_to_mon12 | output | 1 | Output 3/4 routed to monitor 1/2 |
| out12_to_mon34 | output | 1 | Output 1/2 routed to monitor 3/4 |
| src_code_err | output | 1 | Sticky unsupported-source flag |

## Verification
The assertions assume that the bus byte and output enable are settled for at least the synchronizer depth before a select rises and stay steady until it has been seen high. Without that, a load pulse could pair a new strobe with old data. The bench keeps every bus phase several clocks long and changes data only while all selects are high, with one exception: the deliberate data change while a select is low, which tests that a low select by itself loads nothing. With that margin, each load pulse lines up with the bus byte that the reference model expects.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
    localparam int NUM_REGS = 3;
    localparam int REG_SYS  = 0;
    localparam int REG_MON  = 1;
    localparam int REG_CLK  = 2;

    localparam logic [1:0] SRC_ILLEGAL = 2'b10;

    typedef enum logic {
        ST_SEL_HIGH,
        ST_SEL_LOW
    } cap_state_t;
endpackage

// File: rtl/xreg_sync.sv
module xreg_sync #(
    parameter int          W      = 8,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] IDLE  = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= IDLE;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/xreg_capture_fsm.sv
module xreg_capture_fsm
    import xreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic oe_n,
    output logic capture
);
    cap_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEL_HIGH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEL_HIGH: if (!sel_n) state_d = ST_SEL_LOW;
            ST_SEL_LOW:  if (sel_n)  state_d = ST_SEL_HIGH;
            default:     state_d = ST_SEL_HIGH;
        endcase
    end

    always_comb begin
        capture = 1'b0;
        unique case (state_q)
            ST_SEL_HIGH: capture = 1'b0;
            ST_SEL_LOW:  capture = sel_n && !oe_n;
            default:     capture = 1'b0;
        endcase
    end

    // R5: a load only follows a cycle in which the select was low
    assert_capture_after_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> $past(!sel_n));

    // R5: one load pulse per select rise
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture);
endmodule

// File: rtl/xreg_word.sv
module xreg_word #(
    parameter int           W   = 8,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= RST;
        else if (load) q <= d;
    end
endmodule

// File: rtl/ext_reg_bank.sv
module ext_reg_bank
    import xreg_pkg::*;
#(
    parameter int           BUS_W       = 8,
    parameter int           SYNC_STAGES = 2,
    parameter logic [BUS_W-1:0] SYS_RST = 8'h08,
    parameter logic [BUS_W-1:0] MON_RST = 8'h00,
    parameter logic [BUS_W-1:0] CLK_RST = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_data,
    input  logic             bus_oe_n,
    input  logic             sel_sys_n,
    input  logic             sel_mon_n,
    input  logic             sel_clk_n,
    output logic [BUS_W-1:0] sys_word,
    output logic [BUS_W-1:0] mon_word,
    output logic [BUS_W-1:0] clk_word,
    output logic             mic_relay,
    output logic             phantom_hi_v,
    output logic             hw_mute,
    output logic             phantom_off,
    output logic [1:0]       in12_src,
    output logic             in34_hiz,
    output logic             codec_run,
    output logic [3:0]       mon_in_paths,
    output logic             out34_to_mon12,
    output logic             out12_to_mon34,
    output logic             src_code_err
);
    localparam int SYNC_W = BUS_W + NUM_REGS + 1;

    logic [SYNC_W-1:0]   raw_vec, syn_vec;
    logic [BUS_W-1:0]    syn_data;
    logic [NUM_REGS-1:0] syn_sel_n;
    logic                syn_oe_n;
    logic [NUM_REGS-1:0] cap;
    logic [BUS_W-1:0]    word_q [NUM_REGS];
    logic                err_q;

    assign raw_vec = {bus_oe_n, sel_clk_n, sel_mon_n, sel_sys_n, bus_data};

    xreg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .IDLE('1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_vec), .q(syn_vec)
    );

    assign syn_data  = syn_vec[BUS_W-1:0];
    assign syn_sel_n = syn_vec[BUS_W +: NUM_REGS];
    assign syn_oe_n  = syn_vec[SYNC_W-1];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [BUS_W-1:0] RV = (i == REG_SYS) ? SYS_RST :
                                          (i == REG_MON) ? MON_RST : CLK_RST;

        xreg_capture_fsm u_fsm (
            .clk(clk), .rst_n(rst_n), .sel_n(syn_sel_n[i]),
            .oe_n(syn_oe_n), .capture(cap[i])
        );

        xreg_word #(.W(BUS_W), .RST(RV)) u_word (
            .clk(clk), .rst_n(rst_n), .load(cap[i]), .d(syn_data), .q(word_q[i])
        );

        // R4: a register only moves in the cycle after its own load pulse
        assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(word_q[i]) |-> $past(cap[i]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else if (cap[REG_SYS] && syn_data[5:4] == SRC_ILLEGAL) err_q <= 1'b1;
    end

    // R8: the flag never clears outside reset
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R8: the flag rises together with an illegal code landing in the system word
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> word_q[REG_SYS][5:4] == SRC_ILLEGAL);

    assign sys_word = word_q[REG_SYS];
    assign mon_word = word_q[REG_MON];
    assign clk_word = word_q[REG_CLK];

    assign mic_relay      = sys_word[0];
    assign phantom_hi_v   = sys_word[1];
    assign hw_mute        = sys_word[2];
    assign phantom_off    = sys_word[3];
    assign in12_src       = sys_word[5:4];
    assign in34_hiz       = sys_word[6];
    assign codec_run      = sys_word[7];
    assign mon_in_paths   = mon_word[3:0];
    assign out34_to_mon12 = mon_word[4];
    assign out12_to_mon34 = mon_word[5];
    assign src_code_err   = err_q;
endmodule

// File: tb/test_ext_reg_bank.sv
module test_ext_reg_bank;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] bus_data = 8'hFF;
    logic       bus_oe_n = 1;
    logic [2:0] sel_n = 3'b111;
    logic [7:0] sys_word, mon_word, clk_word;
    logic       mic_relay, phantom_hi_v, hw_mute, phantom_off, in34_hiz, codec_run;
    logic [1:0] in12_src;
    logic [3:0] mon_in_paths;
    logic       out34_to_mon12, out12_to_mon34, src_code_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ext_reg_bank i_ext_reg_bank (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_oe_n(bus_oe_n),
        .sel_sys_n(sel_n[0]), .sel_mon_n(sel_n[1]), .sel_clk_n(sel_n[2]),
        .sys_word(sys_word), .mon_word(mon_word), .clk_word(clk_word),
        .mic_relay(mic_relay), .phantom_hi_v(phantom_hi_v), .hw_mute(hw_mute),
        .phantom_off(phantom_off), .in12_src(in12_src), .in34_hiz(in34_hiz),
        .codec_run(codec_run), .mon_in_paths(mon_in_paths),
        .out34_to_mon12(out34_to_mon12), .out12_to_mon34(out12_to_mon34),
        .src_code_err(src_code_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: inputs seen two edges late, load on an observed rise with enable low
    logic [11:0] seen [$];
    logic [7:0]  m_word [3];
    logic [2:0]  m_was_low;
    logic        m_err;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen = {};
            seen.push_back(12'hFFF);
            seen.push_back(12'hFFF);
            m_word[0] = 8'h08; m_word[1] = 8'h00; m_word[2] = 8'h00;
            m_was_low = 3'b000;
            m_err = 0;
        end else begin
            logic [11:0] v;
            v = seen.pop_front();
            seen.push_back({bus_oe_n, sel_n, bus_data});
            for (int r = 0; r < 3; r++) begin
                if (m_was_low[r] && v[8+r] && !v[11]) begin
                    m_word[r] = v[7:0];
                    if (r == 0 && v[5:4] == 2'b10) m_err = 1;
                end
                m_was_low[r] = !v[8+r];
            end
        end
    end

    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            chk("R2 sys model", sys_word, m_word[0]);
            chk("R4 mon model", mon_word, m_word[1]);
            chk("R4 clk model", clk_word, m_word[2]);
            chk("R8 err model", src_code_err, m_err);
        end
    end

    task automatic wr(input logic [2:0] mask, input logic [7:0] d, input bit oe_low);
        @(negedge clk) bus_data = d;
        repeat (3) @(negedge clk);
        bus_oe_n = !oe_low;
        repeat (3) @(negedge clk);
        sel_n = sel_n & ~mask;
        repeat (4) @(negedge clk);
        sel_n = sel_n | mask;
        repeat (5) @(negedge clk);
        bus_oe_n = 1;
        bus_data = 8'hFF;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        chk("R1 sys", sys_word, 8'h08);
        chk("R1 mon", mon_word, 8'h00);
        chk("R1 clk", clk_word, 8'h00);
        chk("R1 err", src_code_err, 0);
        chk("R6 reset codec_run", codec_run, 0);
        chk("R6 reset phantom_off", phantom_off, 1);

        // R2 latency: set up a system write, then time the select rise
        bus_data = 8'h9B;
        repeat (3) @(negedge clk);
        bus_oe_n = 0;
        repeat (3) @(negedge clk);
        sel_n[0] = 0;
        repeat (4) @(negedge clk);
        sel_n[0] = 1;
        @(posedge clk); #5 chk("R2 edge1 unchanged", sys_word, 8'h08);
        @(posedge clk); #5 chk("R2 edge2 unchanged", sys_word, 8'h08);
        @(posedge clk); #5 chk("R2 edge3 loaded", sys_word, 8'h9B);
        repeat (3) @(negedge clk);
        bus_oe_n = 1; bus_data = 8'hFF;
        repeat (4) @(negedge clk);
        // R6 decode of 0x9B
        chk("R6 mic_relay", mic_relay, 1);
        chk("R6 phantom_hi_v", phantom_hi_v, 1);
        chk("R6 hw_mute", hw_mute, 0);
        chk("R6 phantom_off", phantom_off, 1);
        chk("R6 in12_src", in12_src, 2'b01);
        chk("R6 in34_hiz", in34_hiz, 0);
        chk("R6 codec_run", codec_run, 1);
        chk("R9 legal no err", src_code_err, 0);

        // R7 monitor decode, R4 isolation
        wr(3'b010, 8'h35, 1);
        chk("R7 mon word", mon_word, 8'h35);
        chk("R7 in paths", mon_in_paths, 4'h5);
        chk("R7 out34_to_mon12", out34_to_mon12, 1);
        chk("R7 out12_to_mon34", out12_to_mon34, 1);
        chk("R4 sys untouched", sys_word, 8'h9B);
        chk("R4 clk untouched", clk_word, 8'h00);

        // R3 enable high: ignored
        wr(3'b100, 8'hC3, 0);
        chk("R3 clk ignored", clk_word, 8'h00);
        wr(3'b100, 8'hC3, 1);
        chk("R2 clk loaded", clk_word, 8'hC3);

        // R5 low select with changing data does nothing; value at rise is taken
        @(negedge clk) bus_data = 8'h11; bus_oe_n = 0;
        repeat (3) @(negedge clk);
        sel_n[1] = 0;
        repeat (4) @(negedge clk);
        bus_data = 8'h22;
        repeat (6) @(negedge clk);
        chk("R5 no load while low", mon_word, 8'h35);
        sel_n[1] = 1;
        repeat (5) @(negedge clk);
        chk("R5 value at rise", mon_word, 8'h22);
        bus_oe_n = 1; bus_data = 8'hFF;
        repeat (4) @(negedge clk);

        // R10 simultaneous selects
        wr(3'b110, 8'h5A, 1);
        chk("R10 mon", mon_word, 8'h5A);
        chk("R10 clk", clk_word, 8'h5A);
        chk("R10 sys held", sys_word, 8'h9B);

        // R9 low-cut code legal
        wr(3'b001, 8'hB0, 1);
        chk("R9 lowcut src", in12_src, 2'b11);
        chk("R9 lowcut no err", src_code_err, 0);

        // R8 illegal code latched and sticky
        wr(3'b001, 8'hE0, 1);
        chk("R8 latched as written", sys_word, 8'hE0);
        chk("R8 err set", src_code_err, 1);
        wr(3'b001, 8'h00, 1);
        chk("R8 err sticky", src_code_err, 1);
        chk("R8 later write", sys_word, 8'h00);

        // R1 reset clears again
        @(negedge clk) rst_n = 0;
        @(negedge clk);
        chk("R1 err cleared", src_code_err, 0);
        chk("R1 sys again", sys_word, 8'h08);
        rst_n = 1;
        repeat (3) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule